// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is a free-running cycle counter paired with a write-only compare register, both reached through one register address. A read of that address returns the counter. A write to it loads the compare register and leaves the counter running undisturbed. The counter is `CNT_W` bits wide, normally 32 or 64. The compare register is `CMP_W` bits wide, 32 by default. It is checked against the low `CMP_W` bits of the counter only, so on a wide counter the match recurs every 2^`CMP_W` cycles.

Software programs the next event by writing a target count. When the low counter bits reach that target, a sticky pending flag is set. The registered interrupt line shows that flag gated by a mask input. A one-cycle acknowledge pulse clears the flag. A match that lands while the mask is high is kept as pending, so the interrupt appears as soon as the mask drops. A target that lies behind the counter is not treated as due. It fires only after the low bits wrap around to it.

The pending flag is a two-state machine. The state ST_IDLE means no event is outstanding, and ST_PEND means an event is waiting for acknowledge. The transition "hit" takes ST_IDLE to ST_PEND on a match. In ST_PEND, "hold" keeps the state when there is no acknowledge, and it also keeps the state when a match and an acknowledge arrive together. The transition "clear" takes ST_PEND back to ST_IDLE on an acknowledge with no match in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: The counter starts at 0 after reset and rises by exactly 1 on every clock. A cycle with `rd_en` high samples the whole counter, all `CNT_W` bits at once. That value appears on `rd_data` from the next cycle and is held until the next read.
- R2: A read returns the counter and never the compare register, even when a write happens in the same cycle.
- R3: A cycle with `wr_en` high loads `wr_data` into the compare register, which is used from the next cycle. The counter sequence is not changed by the write.
- R4: A match occurs when the low `CMP_W` bits of the counter equal the compare register. On a match, ST_PEND is entered at the following clock edge ("hit").
- R5: If the compare value written is already behind the low counter bits, no interrupt occurs until those bits wrap through zero and reach the value again.
- R6: The pending state is sticky until `irq_ack` is high for a cycle ("clear"). If a match and an acknowledge happen in the same cycle, the state stays in ST_PEND.
- R7: `irq` is a register loaded each cycle with (state is ST_PEND) AND NOT `irq_mask`. A match while masked still enters ST_PEND, and `irq` rises one cycle after the mask is cleared.
- R8: Synchronous active-high `rst` clears the counter, the compare register, the pending state, `irq` and `rd_data`. Because both the counter and the compare register are 0, the first cycle after reset matches: ST_PEND is entered, and `irq` reads 1 two clocks after reset is released if the mask is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for the shared address |
| rd_data | output | CNT_W | Counter value captured by the last read |
| wr_en | input | 1 | Write strobe for the shared address |
| wr_data | input | CMP_W | New compare value |
| irq_mask | input | 1 | High blocks the interrupt output |
| irq_ack | input | 1 | One-cycle pulse that clears a pending event |
| irq | output | 1 | Registered, masked interrupt request |

## Verification
The clocked properties assume that `rst` is high at the first clock edge. They make no assumption about the values of `irq_mask`, `irq_ack`, `rd_en` or `wr_en`, which may take any value in any cycle. The stimulus holds reset from time zero. It changes inputs only on the falling edge and gives the acknowledge as single-cycle pulses. It aims most compare writes at counts a few cycles ahead, so each event lands at a known cycle. A second instance with a narrow compare field makes the wrap-around case reachable in a short run.

// File: rtl/itm_pkg.sv
package itm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } itm_state_e;
endpackage

// File: rtl/itm_counter.sv
module itm_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + STEP;
    end

    assign cnt_o = cnt_q;

    // R1: steady +1 progression once out of reset
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + STEP);

    // R8: reset clears the counter
    p_cnt_reset_r8: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: rtl/itm_compare.sv
module itm_compare #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    input  logic [CMP_W-1:0] cnt_low,
    output logic             match_o
);
    logic [CMP_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)        cmp_q <= '0;
        else if (wr_en) cmp_q <= wr_data;
    end

    assign match_o = (cnt_low == cmp_q);

    // R3: a write lands in the compare register
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cmp_q == $past(wr_data));

    // R3: with no write the compare value holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmp_q));
endmodule

// File: rtl/itm_irq_fsm.sv
module itm_irq_fsm
    import itm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic ack,
    input  logic mask,
    output logic irq_o
);
    itm_state_e state_q, state_d;
    logic       irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (match) state_d = ST_PEND;           // hit
            ST_PEND: if (ack && !match) state_d = ST_IDLE;   // clear, else hold
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (state_q == ST_PEND) && !mask;
    end

    assign irq_o = irq_q;

    // R4: a match always leads to the pending state
    p_hit_r4: assert property (@(posedge clk) disable iff (rst)
        match |=> state_q == ST_PEND);

    // R6: pending is sticky without acknowledge
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND && !ack) |=> state_q == ST_PEND);

    // R6: acknowledge without a match clears
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND && ack && !match) |=> state_q == ST_IDLE);

    // R7: no interrupt follows an idle cycle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |=> !irq_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    input  logic             irq_mask,
    input  logic             irq_ack,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rd_q;
    logic             match;

    itm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    itm_compare #(.CMP_W(CMP_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_low (cnt[CMP_W-1:0]),
        .match_o (match)
    );

    itm_irq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .match (match),
        .ack   (irq_ack),
        .mask  (irq_mask),
        .irq_o (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= cnt;
    end

    assign rd_data = rd_q;

    // R1: a read returns the full counter sampled in the strobe cycle
    p_read_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_data == $past(cnt));

    // R3: a write leaves the counter progression intact
    p_wr_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt == $past(cnt) + ONE);

    // R7: a masked cycle yields no interrupt in the next
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        irq_mask |=> !irq);

    // R8: reset clears the output registers
    p_out_reset_r8: assert property (@(posedge clk)
        rst |=> (!irq && rd_data == '0));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    // each entry: bit 16 = mask during the event, bits 15:0 = cycles ahead
    localparam logic [16:0] VEC [0:5] = '{
        17'h0_0001, 17'h1_0003, 17'h0_0014,
        17'h1_0064, 17'h0_0002, 17'h1_0007
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0, irq_mask = 1'b0, irq_ack = 1'b0;
    logic [31:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        irq;

    logic        wr_en_w = 1'b0, irq_ack_w = 1'b0;
    logic [11:0] wr_data_w = '0;
    logic [31:0] rd_data_w;
    logic        irq_w;

    int ncyc = 0;
    int all_cyc = 0;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask),
        .irq_ack(irq_ack), .irq(irq)
    );

    interval_timer #(.CNT_W(32), .CMP_W(12)) dut_w (
        .clk(clk), .rst(rst), .rd_en(1'b0), .rd_data(rd_data_w),
        .wr_en(wr_en_w), .wr_data(wr_data_w), .irq_mask(1'b0),
        .irq_ack(irq_ack_w), .irq(irq_w)
    );

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
        all_cyc <= all_cyc + 1;
        if (all_cyc > WATCHDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_until(input int t);
        while (ncyc < t) @(negedge clk);
    endtask

    task automatic do_read(input string tag);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == 64'(ncyc - 1), tag, rd_data, 64'(ncyc - 1));
    endtask

    task automatic ack_main();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R8 irq low in reset", 64'(irq), 64'd0);
        check(rd_data == 64'd0, "R8 rd_data zero in reset", rd_data, 64'd0);
        rst = 1'b0;
        wait_until(2);
        check(irq == 1'b1, "R8 zero compare matches first count", 64'(irq), 64'd1);
        irq_ack_w = 1'b1;
        ack_main();
        irq_ack_w = 1'b0;
        check(irq == 1'b0, "R6 acknowledge clears", 64'(irq), 64'd0);

        do_read("R1 read after reset");
        repeat (5) @(negedge clk);
        do_read("R1 read later");

        // read and write together
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'hFFFF_F000;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check(rd_data == 64'(ncyc - 1), "R2 read returns counter not compare",
              rd_data, 64'(ncyc - 1));
        repeat (7) @(negedge clk);
        do_read("R3 counter undisturbed by write");

        for (int i = 0; i < 6; i++) begin
            int d;
            int w;
            bit m;
            d = int'(VEC[i][15:0]);
            m = VEC[i][16];
            irq_mask = m;
            w = ncyc;
            wr_en = 1'b1; wr_data = 32'(w + d);
            @(negedge clk);
            wr_en = 1'b0;
            wait_until(w + d + 1);
            check(irq == 1'b0, "R4 no irq before match registers", 64'(irq), 64'd0);
            wait_until(w + d + 2);
            check(irq == !m, "R4 R7 irq after match", 64'(irq), 64'(!m));
            if (m) begin
                irq_mask = 1'b0;
                @(negedge clk);
                check(irq == 1'b1, "R7 masked match fires on unmask", 64'(irq), 64'd1);
            end
            ack_main();
            check(irq == 1'b0, "R6 acknowledge clears", 64'(irq), 64'd0);
        end

        // match and acknowledge in the same cycle
        begin
            int w;
            int x;
            w = ncyc;
            wr_en = 1'b1; wr_data = 32'(w + 4);
            @(negedge clk);
            wr_en = 1'b0;
            wait_until(w + 6);
            check(irq == 1'b1, "R4 event pending", 64'(irq), 64'd1);
            x = ncyc;
            wr_en = 1'b1; wr_data = 32'(x + 4);
            @(negedge clk);
            wr_en = 1'b0;
            wait_until(x + 4);
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            wait_until(x + 7);
            check(irq == 1'b1, "R6 match wins over acknowledge", 64'(irq), 64'd1);
            ack_main();
            check(irq == 1'b0, "R6 later acknowledge clears", 64'(irq), 64'd0);
        end

        // compare value already passed: fires only after low bits wrap
        begin
            int w;
            bit early;
            early = 1'b0;
            w = ncyc;
            wr_en_w = 1'b1; wr_data_w = 12'(w - 10);
            @(negedge clk);
            wr_en_w = 1'b0;
            irq_ack_w = 1'b1;
            @(negedge clk);
            irq_ack_w = 1'b0;
            repeat (2) @(negedge clk);
            while (ncyc < w + 4087) begin
                if (irq_w) early = 1'b1;
                @(negedge clk);
            end
            if (irq_w) early = 1'b1;
            check(!early, "R5 no irq before wrap", 64'(early), 64'd0);
            wait_until(w + 4088);
            check(irq_w == 1'b1, "R5 irq after low bits wrap", 64'(irq_w), 64'd1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule